// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block erases a byte range of a page-organised serial flash without software stepping through it. A caller gives a start byte offset and a byte length and pulses start. The block walks the range one step at a time. Each step is an erase of either a single page or an eight-page block, whichever covers the most ground from the current position. The block sends the four command bytes over a byte request/acknowledge link to an external SPI shifter. It then polls the device status byte until the ready bit is set and moves on to the next step.

The page size and the left shift that turns a page index into a device address are parameters, so the block can serve parts with page sizes that are not powers of two. Poll spacing and the give-up time are counted in milliseconds from a prescaler sized by the clock frequency parameter. The caller sees a busy level, a one-cycle done pulse and two error flags: misaligned arguments, and a device that never became ready.

Top module: `flash_erase_seq`

## Requirements
- R1: If the start offset or the length is not a whole multiple of PAGE_SIZE, err_align rises together with a done pulse, busy stays low and no chip-select session occurs.
- R2: An eight-page block erase (opcode 0x50) is used when the current page index has its three low bits zero and at least 8*PAGE_SIZE bytes remain. Every other step is a single-page erase (opcode 0x81).
- R3: The device address is the page index shifted left by ADDR_SHIFT. A command sends four bytes in this order: the opcode, address bits 23:16, address bits 15:8, then 0x00.
- R4: A status poll is one session of two bytes: 0xD7, then a 0x00 filler byte. The byte received during the filler is the status, and the device counts as ready when status bit 7 is 1. No other status bit has an effect.
- R5: After a not-ready status, the next poll session starts two to three milliseconds later, at CLK_KHZ cycles per millisecond.
- R6: If a poll reads not-ready and TIMEOUT_MS milliseconds have passed since the erase command ended, the block stops, sets err_timeout and pulses done.
- R7: After a ready status, the offset advances and the remaining length shrinks by the size just erased (one block or one page). The block repeats until nothing remains. A zero length completes at once with no command.
- R8: spi_cs is high for the whole of each command session and each poll session, and low for at least one cycle between any two sessions.
- R9: busy is high from an accepted start until the cycle done pulses. A start pulse while busy is ignored.
- R10: tx_byte holds steady while tx_req is high and tx_ack is low. Each byte is consumed exactly once, in the cycle where tx_ack is high.
- R11: done is a one-cycle pulse at the end of every operation. err_align and err_timeout keep their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin an erase; ignored while busy |
| start_ofs | input | OFS_W | Start byte offset |
| start_len | input | OFS_W | Length in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_align | output | 1 | Offset or length not page aligned |
| err_timeout | output | 1 | Device never reported ready |
| spi_cs | output | 1 | Chip select request to the shifter, active high |
| tx_req | output | 1 | Byte transfer request |
| tx_byte | output | 8 | Byte to shift out |
| tx_ack | input | 1 | Shifter has taken the byte; rx_byte valid |
| rx_byte | input | 8 | Byte shifted in during the acknowledged transfer |

## Verification
A wrong page counter or remaining-length register shows up at the link within the next command session, as a wrong opcode or wrong address bytes. A wrong byte index shows up within one session as a wrong byte count per chip-select window. A stuck poll state shows up as poll spacing outside the two-to-three millisecond window, or as a poll count at timeout far from TIMEOUT_MS divided by the spacing, and this appears within one interval. Flags that are cleared badly or fire twice are visible on the next done pulse.

// File: rtl/fes_pkg.sv
package fes_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_CMD     = 3'd1,
        S_GAP     = 3'd2,
        S_POLL_OP = 3'd3,
        S_POLL_RD = 3'd4,
        S_WAIT    = 3'd5,
        S_NEXT    = 3'd6
    } fes_state_e;

    localparam logic [7:0] OPC_PAGE   = 8'h81;
    localparam logic [7:0] OPC_BLOCK  = 8'h50;
    localparam logic [7:0] OPC_STATUS = 8'hD7;
    localparam int         BLK_PAGES  = 8;
endpackage

// File: rtl/fes_tick.sv
module fes_tick #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fes_cmd.sv
module fes_cmd
    import fes_pkg::*;
#(
    parameter int OFS_W      = 24,
    parameter int PAGE_SIZE  = 264,
    parameter int ADDR_SHIFT = 9
) (
    input  logic [OFS_W-1:0] page,
    input  logic [OFS_W-1:0] remain,
    input  logic [1:0]       idx,
    output logic             blk,
    output logic [7:0]       cmd_byte
);
    localparam int WW = OFS_W + ADDR_SHIFT;
    localparam logic [OFS_W-1:0] BLK_BYTES = OFS_W'(BLK_PAGES * PAGE_SIZE);

    logic [WW-1:0] dev_addr;

    always_comb begin
        dev_addr = {page, {ADDR_SHIFT{1'b0}}};
        blk      = (page[2:0] == 3'd0) && (remain >= BLK_BYTES);
        case (idx)
            2'd0:    cmd_byte = blk ? OPC_BLOCK : OPC_PAGE;
            2'd1:    cmd_byte = dev_addr[23:16];
            2'd2:    cmd_byte = dev_addr[15:8];
            default: cmd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int OFS_W      = 24,
    parameter int PAGE_SIZE  = 264,
    parameter int ADDR_SHIFT = 9,
    parameter int CLK_KHZ    = 125000,
    parameter int POLL_MS    = 3,
    parameter int TIMEOUT_MS = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] start_len,
    output logic             busy,
    output logic             done,
    output logic             err_align,
    output logic             err_timeout,
    output logic             spi_cs,
    output logic             tx_req,
    output logic [7:0]       tx_byte,
    input  logic             tx_ack,
    input  logic [7:0]       rx_byte
);
    localparam int MS_W = $clog2(TIMEOUT_MS + 1);
    localparam int PW   = $clog2(POLL_MS + 1);
    localparam logic [OFS_W-1:0] PAGE_V = OFS_W'(PAGE_SIZE);
    localparam logic [OFS_W-1:0] BLK_V  = OFS_W'(BLK_PAGES * PAGE_SIZE);
    localparam logic [MS_W-1:0]  TO_V   = MS_W'(TIMEOUT_MS);
    localparam logic [PW-1:0]    PL_V   = PW'(POLL_MS - 1);

    typedef struct packed {
        fes_state_e       state;
        logic [1:0]       idx;
        logic [OFS_W-1:0] page;
        logic [OFS_W-1:0] remain;
        logic [PW-1:0]    wait_ms;
        logic [MS_W-1:0]  elap;
        logic             done;
        logic             e_al;
        logic             e_to;
    } regs_t;

    regs_t d, q;

    logic       ms_tick;
    logic       blk;
    logic [7:0] cmd_byte;
    logic [OFS_W-1:0] step;
    logic       misal;
    logic       in_session;

    fes_tick #(.DIV(CLK_KHZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q.state == S_IDLE),
        .tick  (ms_tick)
    );

    fes_cmd #(.OFS_W(OFS_W), .PAGE_SIZE(PAGE_SIZE), .ADDR_SHIFT(ADDR_SHIFT)) u_cmd (
        .page     (q.page),
        .remain   (q.remain),
        .idx      (q.idx),
        .blk      (blk),
        .cmd_byte (cmd_byte)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        misal  = ((start_ofs % PAGE_V) != '0) || ((start_len % PAGE_V) != '0);
        step   = blk ? BLK_V : PAGE_V;
        if (ms_tick && (q.elap != TO_V)) d.elap = q.elap + 1'b1;

        case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.e_al = 1'b0;
                    d.e_to = 1'b0;
                    if (misal) begin
                        d.e_al = 1'b1;
                        d.done = 1'b1;
                    end else if (start_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.page   = start_ofs / PAGE_V;
                        d.remain = start_len;
                        d.idx    = '0;
                        d.state  = S_CMD;
                    end
                end
            end
            S_CMD: begin
                if (tx_ack) begin
                    if (q.idx == 2'd3) begin
                        d.state = S_GAP;
                        d.elap  = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_GAP:     d.state = S_POLL_OP;
            S_POLL_OP: if (tx_ack) d.state = S_POLL_RD;
            S_POLL_RD: begin
                if (tx_ack) begin
                    if (rx_byte[7]) begin
                        d.state = S_NEXT;
                    end else if (q.elap >= TO_V) begin
                        d.e_to  = 1'b1;
                        d.done  = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        d.wait_ms = '0;
                        d.state   = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (ms_tick) begin
                    if (q.wait_ms >= PL_V) d.state = S_POLL_OP;
                    else                   d.wait_ms = q.wait_ms + 1'b1;
                end
            end
            S_NEXT: begin
                d.remain = q.remain - step;
                d.page   = q.page + (blk ? OFS_W'(BLK_PAGES) : OFS_W'(1));
                d.idx    = '0;
                if (q.remain == step) begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_CMD;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        in_session  = (q.state == S_CMD) || (q.state == S_POLL_OP) || (q.state == S_POLL_RD);
        spi_cs      = in_session;
        tx_req      = in_session;
        tx_byte     = (q.state == S_CMD) ? cmd_byte :
                      (q.state == S_POLL_OP) ? OPC_STATUS : 8'h00;
        busy        = (q.state != S_IDLE);
        done        = q.done;
        err_align   = q.e_al;
        err_timeout = q.e_to;
    end
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err_align,
    input logic       err_timeout,
    input logic       spi_cs,
    input logic       tx_req,
    input logic       tx_ack,
    input logic [7:0] tx_byte
);
    a_r8_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs |-> busy);

    a_r8_req_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> spi_cs);

    a_r10_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_byte)));

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_end_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r1_align_no_session: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |-> !spi_cs);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_align && err_timeout));
endmodule

bind flash_erase_seq fes_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err_align   (err_align),
    .err_timeout (err_timeout),
    .spi_cs      (spi_cs),
    .tx_req      (tx_req),
    .tx_ack      (tx_ack),
    .tx_byte     (tx_byte)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
    localparam int PG  = 264;
    localparam int SH  = 9;
    localparam int KHZ = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [23:0] start_ofs = '0;
    logic [23:0] start_len = '0;
    logic busy, done, err_align, err_timeout, spi_cs, tx_req, tx_ack;
    logic [7:0] tx_byte, rx_byte;

    always #4 clk = ~clk;

    flash_erase_seq #(.OFS_W(24), .PAGE_SIZE(PG), .ADDR_SHIFT(SH), .CLK_KHZ(KHZ),
                      .POLL_MS(3), .TIMEOUT_MS(30)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(start_ofs),
        .start_len(start_len), .busy(busy), .done(done), .err_align(err_align),
        .err_timeout(err_timeout), .spi_cs(spi_cs), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_ack(tx_ack), .rx_byte(rx_byte));

    // device model
    int  cfg_busy = 0;        // not-ready polls per command, -1 = never ready
    logic log_clr = 1'b0;
    int  busy_left, nb, ncmd, npoll, cyc, poll_end, gap_min, gap_max;
    logic [7:0] s0, last_stat;
    logic cs_q, prev_nr;
    logic [7:0] lg_op [0:31];
    logic [7:0] lg_a1 [0:31];
    logic [7:0] lg_a2 [0:31];
    logic [7:0] lg_a3 [0:31];
    int  lg_nb [0:31];
    int  poll_nb_bad;
    logic [7:0] sb [0:3];

    always @(posedge clk) begin
        tx_ack <= 1'b0;
        cyc    <= cyc + 1;
        cs_q   <= spi_cs;
        if (!rst_n || log_clr) begin
            nb <= 0; ncmd <= 0; npoll <= 0; gap_min <= 1000000; gap_max <= 0;
            prev_nr <= 1'b0; poll_nb_bad <= 0; busy_left <= cfg_busy; rx_byte <= 8'h00;
            if (!rst_n) begin cyc <= 0; tx_ack <= 1'b0; cs_q <= 1'b0; end
        end else begin
            if (spi_cs && tx_req && !tx_ack) begin
                tx_ack <= 1'b1;
                if (nb < 4) sb[nb] <= tx_byte;
                if (nb == 0) s0 <= tx_byte;
                rx_byte <= 8'h00;
                if (nb == 1 && s0 == 8'hD7) begin
                    rx_byte   <= (busy_left == 0) ? 8'hBC : 8'h3C;
                    last_stat <= (busy_left == 0) ? 8'hBC : 8'h3C;
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end
                nb <= nb + 1;
            end
            if (!cs_q && spi_cs && prev_nr) begin
                if (cyc - poll_end < gap_min) gap_min <= cyc - poll_end;
                if (cyc - poll_end > gap_max) gap_max <= cyc - poll_end;
            end
            if (cs_q && !spi_cs) begin
                nb <= 0;
                if (s0 == 8'hD7) begin
                    npoll    <= npoll + 1;
                    poll_end <= cyc;
                    prev_nr  <= !last_stat[7];
                    if (nb != 2) poll_nb_bad <= poll_nb_bad + 1;
                end else begin
                    prev_nr <= 1'b0;
                    if (ncmd < 32) begin
                        lg_op[ncmd] <= sb[0]; lg_a1[ncmd] <= sb[1];
                        lg_a2[ncmd] <= sb[2]; lg_a3[ncmd] <= sb[3];
                        lg_nb[ncmd] <= nb;
                    end
                    ncmd      <= ncmd + 1;
                    busy_left <= cfg_busy;
                end
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log(input int busy_polls);
        @(negedge clk);
        cfg_busy = busy_polls;
        log_clr  = 1'b1;
        @(negedge clk);
        log_clr  = 1'b0;
    endtask

    task automatic run_op(input int ofs, input int len, output int ndone);
        int lim;
        @(negedge clk);
        start_ofs = 24'(ofs);
        start_len = 24'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        lim = 0;
        while (!done && lim < 20000) begin @(negedge clk); lim++; end
        if (done) ndone = 1;
        @(negedge clk);
        if (done) ndone++;
        chk(lim < 20000, "R9 op completes", lim, 0);
    endtask

    task automatic chk_cmd(input int i, input int op, input int page, input string req);
        int a;
        a = page << SH;
        chk(lg_op[i] == 8'(op), req, int'(lg_op[i]), op);
        chk(lg_a1[i] == 8'(a >> 16) && lg_a2[i] == 8'(a >> 8) && lg_a3[i] == 8'h00,
            "R3 address bytes", int'({lg_a1[i], lg_a2[i], lg_a3[i]}), (a & 32'hFFFF00));
        chk(lg_nb[i] == 4, "R8 R10 four bytes per command session", lg_nb[i], 4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !spi_cs && !tx_req && !err_align && !err_timeout,
            "R9 reset idle", int'({busy, done, spi_cs, tx_req}), 0);
    endtask

    task automatic t_align();
        int nd;
        clear_log(0);
        run_op(100, PG, nd);
        chk(err_align == 1'b1, "R1 misaligned offset flag", int'(err_align), 1);
        chk(ncmd == 0 && npoll == 0, "R1 no session", ncmd + npoll, 0);
        chk(nd == 1, "R11 done single pulse", nd, 1);
        clear_log(0);
        run_op(PG, PG + 5, nd);
        chk(err_align == 1'b1 && ncmd == 0, "R1 misaligned length", ncmd, 0);
        @(negedge clk);
        chk(err_align == 1'b1, "R11 flag held", int'(err_align), 1);
    endtask

    task automatic t_single();
        int nd;
        clear_log(0);
        run_op(3 * PG, PG, nd);
        chk(ncmd == 1 && npoll == 1, "R7 one page one poll", ncmd * 10 + npoll, 11);
        chk_cmd(0, 8'h81, 3, "R2 page opcode");
        chk(!err_align && !err_timeout, "R11 flags cleared by start",
            int'({err_align, err_timeout}), 0);
        chk(poll_nb_bad == 0, "R4 two-byte poll session", poll_nb_bad, 0);
    endtask

    task automatic t_mixed();
        int nd;
        int exp_op [5] = '{8'h81, 8'h81, 8'h50, 8'h81, 8'h81};
        int exp_pg [5] = '{6, 7, 8, 16, 17};
        clear_log(2);
        run_op(6 * PG, 12 * PG, nd);
        chk(ncmd == 5, "R7 step count mixed", ncmd, 5);
        for (int i = 0; i < 5; i++) chk_cmd(i, exp_op[i], exp_pg[i], "R2 mixed opcode");
        chk(npoll == 15, "R4 ready only on bit7", npoll, 15);
        chk(gap_min >= 15 && gap_max <= 28, "R5 poll spacing", gap_min * 1000 + gap_max, 24);
        chk(poll_nb_bad == 0 && !err_timeout, "R4 poll sessions", poll_nb_bad, 0);
    endtask

    task automatic t_high_block();
        int nd;
        clear_log(0);
        run_op(200 * PG, 8 * PG, nd);
        chk(ncmd == 1, "R2 single block", ncmd, 1);
        chk_cmd(0, 8'h50, 200, "R2 block opcode");
    endtask

    task automatic t_short();
        int nd;
        clear_log(0);
        run_op(0, 7 * PG, nd);
        chk(ncmd == 7, "R2 under one block uses pages", ncmd, 7);
        chk_cmd(0, 8'h81, 0, "R2 aligned page short length");
        chk_cmd(6, 8'h81, 6, "R7 last page");
    endtask

    task automatic t_timeout();
        int nd;
        clear_log(-1);
        run_op(PG, PG, nd);
        chk(err_timeout == 1'b1, "R6 timeout flag", int'(err_timeout), 1);
        chk(ncmd == 1, "R6 no advance on timeout", ncmd, 1);
        chk(npoll >= 9 && npoll <= 13, "R6 poll count to timeout", npoll, 11);
        chk(nd == 1, "R11 done on timeout", nd, 1);
        clear_log(0);
        run_op(0, 0, nd);
        chk(!err_timeout && ncmd == 0 && nd == 1, "R7 zero length", ncmd, 0);
        chk(!err_timeout, "R11 flag cleared", int'(err_timeout), 0);
    endtask

    task automatic t_ignore();
        int nd;
        int lim;
        clear_log(3);
        @(negedge clk);
        start_ofs = 24'(8 * PG); start_len = 24'(PG); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R9 busy during op", int'(busy), 1);
        start_ofs = 24'd0; start_len = 24'(16 * PG); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lim = 0;
        while (!done && lim < 20000) begin @(negedge clk); lim++; end
        repeat (40) @(negedge clk);
        chk(ncmd == 1, "R9 start ignored while busy", ncmd, 1);
        chk_cmd(0, 8'h81, 8, "R9 original op kept");
        chk(!busy, "R9 idle after", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_align();
        t_single();
        t_mixed();
        t_high_block();
        t_short();
        t_timeout();
        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule